// File: doc/BRIEF.md
# Single and Pair Core Allocator

This block manages a pool of 16 processing cores and hands out free ones on request. Each request asks for either a single core or an aligned pair of cores. The pair is always the two cores 2k and 2k+1, and both are taken together in one step. The block keeps a 16-bit occupancy mask with one bit per core. On every accepted request it reports the granted core number. For a pair this is the even member. When no suitable core or pair is free, it reports a failure.

Single cores are always taken from the lowest free position. A mode input sets the pair search direction: from the top of the pool downward, or from the bottom upward. Pairs taken from the top tend to stay clear of the singles that fill up from core 0, which limits fragmentation. A release port frees one core or one aligned pair. A release that arrives in the same cycle as a request is applied first, so the search sees the freed cores. Loading and starting the cores is left to other logic.

Top module: `core_pool_alloc`

## Requirements
- R1: While reset is high, and on the first sample after it, the occupancy mask is all zero and the grant outputs (valid, fail, index) are zero.
- R2: Only bit 6 of the 8-bit request command is decoded: 0 asks for one core, 1 asks for an aligned pair. All other command bits have no effect on the grant.
- R3: A single-core request takes the lowest-numbered free core, sets its occupancy bit and returns its number.
- R4: A pair request only takes cores 2k and 2k+1 with both free. Both occupancy bits are set on the same clock edge, and the returned index is the even core 2k.
- R5: With the mode input high, pairs are searched from pair 7 (cores 14 and 15) downward. With it low, they are searched from pair 0 upward.
- R6: When no free core, or no free aligned pair, exists for the request, the fail bit is set with index 0, and the grant sets no occupancy bit.
- R7: A release and a request in the same cycle are handled with the release first. The search sees the mask with the released bits already cleared.
- R8: A pair release clears both bits of the aligned pair that holds the given index, whichever member is named. Releasing a core that is already free leaves the mask unchanged.
- R9: The grant is registered. The valid output is high for exactly one cycle, on the cycle after each request cycle, and is low (with fail and index zero) after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Allocation request strobe |
| req_cmd | input | 8 | Request command; bit 6 selects single (0) or pair (1) |
| pair_top_down | input | 1 | 1: pairs searched from the top; 0: from the bottom |
| rel_valid | input | 1 | Release strobe |
| rel_pair | input | 1 | 1: release the aligned pair holding rel_idx; 0: release one core |
| rel_idx | input | 4 | Core number to release |
| gnt_valid | output | 1 | Grant result valid, one cycle after a request |
| gnt_fail | output | 1 | Request could not be satisfied |
| gnt_idx | output | 4 | Granted core number (even core for a pair) |
| occupancy | output | 16 | Current occupancy mask, bit n set when core n is in use |

## Verification
The hardest state to reach from the ports is a fragmented mask. In that state free single cores remain, but no aligned pair is whole. A pair request must then fail while a single request still succeeds. The stimulus reaches this state by filling the pool completely through a mix of singles and pairs in both directions. It then releases one odd-numbered core in the same cycle as a pair request, so the release-before-search ordering and the pair-alignment rule are exercised on the same edge. Holes below occupied cores are also made by releases, to show that singles fill the lowest hole first.

// File: rtl/core_alloc_pkg.sv
package core_alloc_pkg;

    localparam int POOL_SIZE = 16;
    localparam int IDX_W     = $clog2(POOL_SIZE);
    localparam int PAIR_CNT  = POOL_SIZE / 2;
    localparam int CMD_W     = 8;
    localparam int SIZE_BIT  = 6;

    typedef enum logic {
        ASK_ONE = 1'b0,
        ASK_TWO = 1'b1
    } ask_size_e;

    typedef struct packed {
        logic             valid;
        logic             fail;
        logic [IDX_W-1:0] idx;
    } grant_t;

    function automatic ask_size_e decode_size(input logic [CMD_W-1:0] cmd);
        return ask_size_e'(cmd[SIZE_BIT]);
    endfunction

    function automatic logic [IDX_W-1:0] pair_base(input logic [IDX_W-1:0] idx);
        return {idx[IDX_W-1:1], 1'b0};
    endfunction

endpackage

// File: rtl/cap_release_mask.sv
module cap_release_mask #(
    parameter int N_CORES = 16,
    parameter int IW      = $clog2(N_CORES)
) (
    input  logic               rel_valid,
    input  logic               rel_pair,
    input  logic [IW-1:0]      rel_idx,
    output logic [N_CORES-1:0] clr_mask
);
    localparam logic [IW-1:0] ONE = IW'(1);

    logic [IW-1:0] even_idx;

    assign even_idx = {rel_idx[IW-1:1], 1'b0};

    always_comb begin
        clr_mask = '0;
        if (rel_valid) begin
            if (rel_pair) begin
                clr_mask[even_idx]       = 1'b1;
                clr_mask[even_idx | ONE] = 1'b1;
            end else begin
                clr_mask[rel_idx] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cap_single_search.sv
module cap_single_search #(
    parameter int N_CORES = 16,
    parameter int IW      = $clog2(N_CORES)
) (
    input  logic [N_CORES-1:0] free_mask,
    output logic               found,
    output logic [IW-1:0]      idx
);
    always_comb begin
        found = |free_mask;
        idx   = '0;
        for (int n = N_CORES - 1; n >= 0; n--) begin
            if (free_mask[n]) idx = IW'(n);
        end
    end
endmodule

// File: rtl/cap_pair_search.sv
module cap_pair_search #(
    parameter int N_PAIRS = 8,
    parameter int IW      = $clog2(2 * N_PAIRS)
) (
    input  logic [2*N_PAIRS-1:0] free_mask,
    input  logic                 top_down,
    output logic                 found,
    output logic [IW-1:0]        base_idx
);
    logic [N_PAIRS-1:0] pair_ok;
    logic [IW-1:0]      up_idx;
    logic [IW-1:0]      down_idx;

    for (genvar k = 0; k < N_PAIRS; k++) begin : gen_pair
        assign pair_ok[k] = free_mask[2*k] & free_mask[2*k+1];
    end

    always_comb begin
        up_idx = '0;
        for (int k = N_PAIRS - 1; k >= 0; k--) begin
            if (pair_ok[k]) up_idx = IW'(2 * k);
        end
    end

    always_comb begin
        down_idx = '0;
        for (int k = 0; k < N_PAIRS; k++) begin
            if (pair_ok[k]) down_idx = IW'(2 * k);
        end
    end

    assign found    = |pair_ok;
    assign base_idx = top_down ? down_idx : up_idx;
endmodule

// File: rtl/core_pool_alloc.sv
module core_pool_alloc
    import core_alloc_pkg::*;
#(
    parameter int N_CORES = POOL_SIZE,
    parameter int CW      = CMD_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic [CW-1:0]                req_cmd,
    input  logic                         pair_top_down,
    input  logic                         rel_valid,
    input  logic                         rel_pair,
    input  logic [$clog2(N_CORES)-1:0]   rel_idx,
    output logic                         gnt_valid,
    output logic                         gnt_fail,
    output logic [$clog2(N_CORES)-1:0]   gnt_idx,
    output logic [N_CORES-1:0]           occupancy
);
    localparam int IW      = $clog2(N_CORES);
    localparam int N_PAIRS = N_CORES / 2;

    logic [N_CORES-1:0] occ_q;
    logic [N_CORES-1:0] occ_d;
    logic [N_CORES-1:0] clr_mask;
    logic [N_CORES-1:0] occ_released;
    logic [N_CORES-1:0] free_mask;
    logic [N_CORES-1:0] set_mask;

    logic               one_found;
    logic [IW-1:0]      one_idx;
    logic               two_found;
    logic [IW-1:0]      two_idx;

    ask_size_e          ask;
    logic               hit;
    logic [IW-1:0]      pick;
    grant_t             grant_q;
    grant_t             grant_d;

    cap_release_mask #(.N_CORES(N_CORES), .IW(IW)) u_rel (
        .rel_valid (rel_valid),
        .rel_pair  (rel_pair),
        .rel_idx   (rel_idx),
        .clr_mask  (clr_mask)
    );

    // Release is folded in before the search sees the mask.
    assign occ_released = occ_q & ~clr_mask;
    assign free_mask    = ~occ_released;

    cap_single_search #(.N_CORES(N_CORES), .IW(IW)) u_one (
        .free_mask (free_mask),
        .found     (one_found),
        .idx       (one_idx)
    );

    cap_pair_search #(.N_PAIRS(N_PAIRS), .IW(IW)) u_two (
        .free_mask (free_mask),
        .top_down  (pair_top_down),
        .found     (two_found),
        .base_idx  (two_idx)
    );

    always_comb begin
        ask      = decode_size(req_cmd);
        hit      = (ask == ASK_TWO) ? two_found : one_found;
        pick     = (ask == ASK_TWO) ? two_idx   : one_idx;
        set_mask = '0;
        if (req_valid && hit) begin
            if (ask == ASK_TWO) set_mask = N_CORES'(3) << pick;
            else                set_mask = N_CORES'(1) << pick;
        end
        occ_d         = occ_released | set_mask;
        grant_d.valid = req_valid;
        grant_d.fail  = req_valid & ~hit;
        grant_d.idx   = (req_valid && hit) ? pick : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q   <= '0;
            grant_q <= '0;
        end else begin
            occ_q   <= occ_d;
            grant_q <= grant_d;
        end
    end

    assign occupancy = occ_q;
    assign gnt_valid = grant_q.valid;
    assign gnt_fail  = grant_q.fail;
    assign gnt_idx   = grant_q.idx;
endmodule

// File: rtl/core_pool_alloc_chk.sv
module core_pool_alloc_chk #(
    parameter int N_CORES = 16,
    parameter int CW      = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       req_valid,
    input logic [CW-1:0]              req_cmd,
    input logic                       pair_top_down,
    input logic                       rel_valid,
    input logic                       rel_pair,
    input logic [$clog2(N_CORES)-1:0] rel_idx,
    input logic                       gnt_valid,
    input logic                       gnt_fail,
    input logic [$clog2(N_CORES)-1:0] gnt_idx,
    input logic [N_CORES-1:0]         occupancy
);
    localparam int IW = $clog2(N_CORES);
    localparam logic [IW-1:0] ONE = IW'(1);

    p_grant_after_req_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> gnt_valid);

    p_no_grant_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!gnt_valid && !gnt_fail));

    p_pair_even_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_cmd[6]) |=> (gnt_fail || !gnt_idx[0]));

    p_pair_both_taken_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_cmd[6]) |=>
            (gnt_fail || (occupancy[gnt_idx] && occupancy[gnt_idx | ONE])));

    p_single_taken_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_cmd[6]) |=> (gnt_fail || occupancy[gnt_idx]));

    p_fail_keeps_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rel_valid) |=> (!gnt_fail || $stable(occupancy)));

    p_idle_keeps_mask_r8: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && !rel_valid) |=> $stable(occupancy));
endmodule

bind core_pool_alloc core_pool_alloc_chk #(.N_CORES(N_CORES), .CW(CW)) u_chk (.*);

// File: tb/core_pool_alloc_tb.sv
module core_pool_alloc_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [7:0]  req_cmd;
    logic        pair_top_down;
    logic        rel_valid;
    logic        rel_pair;
    logic [3:0]  rel_idx;
    logic        gnt_valid;
    logic        gnt_fail;
    logic [3:0]  gnt_idx;
    logic [15:0] occupancy;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    core_pool_alloc u_dut (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_cmd       (req_cmd),
        .pair_top_down (pair_top_down),
        .rel_valid     (rel_valid),
        .rel_pair      (rel_pair),
        .rel_idx       (rel_idx),
        .gnt_valid     (gnt_valid),
        .gnt_fail      (gnt_fail),
        .gnt_idx       (gnt_idx),
        .occupancy     (occupancy)
    );

    typedef struct packed {
        logic        rq;
        logic [7:0]  cmd;
        logic        td;
        logic        rv;
        logic        rp;
        logic [3:0]  ri;
        logic        ev;
        logic        ef;
        logic [3:0]  ei;
        logic [15:0] eo;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VT [NV] = '{
        // R3: singles fill from core 0
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 4'd0,  16'h0001, 4'd3},
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 4'd1,  16'h0003, 4'd3},
        // R4: bottom pair lands on 2/3
        '{1'b1, 8'h40, 1'b0, 1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 4'd2,  16'h000F, 4'd4},
        // R5: top pair lands on 14/15
        '{1'b1, 8'h40, 1'b1, 1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 4'd14, 16'hC00F, 4'd5},
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 4'd4,  16'hC01F, 4'd3},
        // R5: bottom pair skips half-used pair 2
        '{1'b1, 8'h40, 1'b0, 1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 4'd6,  16'hC0DF, 4'd5},
        // R9: release only, no grant pulse
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 4'd1,  1'b0, 1'b0, 4'd0,  16'hC0DD, 4'd9},
        // R3: lowest hole refilled
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 4'd1,  16'hC0DF, 4'd3},
        '{1'b1, 8'h40, 1'b1, 1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 4'd12, 16'hF0DF, 4'd5},
        // R8: pair release by odd member
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 4'd13, 1'b0, 1'b0, 4'd0,  16'hC0DF, 4'd8},
        // R8: release of free core 5 ignored
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 4'd5,  1'b0, 1'b0, 4'd0,  16'hC0DF, 4'd8},
        // R2: other command bits set, bit 6 clear -> single
        '{1'b1, 8'hBF, 1'b0, 1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 4'd5,  16'hC0FF, 4'd2},
        '{1'b1, 8'h40, 1'b1, 1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 4'd12, 16'hF0FF, 4'd2},
        '{1'b1, 8'h40, 1'b1, 1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 4'd10, 16'hFCFF, 4'd5},
        '{1'b1, 8'h40, 1'b0, 1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 4'd8,  16'hFFFF, 4'd4},
        // R6: full pool fails
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0,  1'b1, 1'b1, 4'd0,  16'hFFFF, 4'd6},
        '{1'b1, 8'h40, 1'b1, 1'b0, 1'b0, 4'd0,  1'b1, 1'b1, 4'd0,  16'hFFFF, 4'd6},
        // R7: release and request together
        '{1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 4'd3,  1'b1, 1'b0, 4'd3,  16'hFFFF, 4'd7},
        '{1'b1, 8'h40, 1'b0, 1'b1, 1'b1, 4'd0,  1'b1, 1'b0, 4'd0,  16'hFFFF, 4'd7},
        // R6: only core 7 free, pair fails
        '{1'b1, 8'hC0, 1'b0, 1'b1, 1'b0, 4'd7,  1'b1, 1'b1, 4'd0,  16'hFF7F, 4'd6},
        '{1'b1, 8'h3F, 1'b0, 1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 4'd7,  16'hFFFF, 4'd2}
    };

    task automatic check(input string rq, input logic ev, input logic ef,
                         input logic [3:0] ei, input logic [15:0] eo);
        n_checks++;
        if (gnt_valid !== ev || gnt_fail !== ef || gnt_idx !== ei || occupancy !== eo) begin
            n_fails++;
            $display("FAIL %s: got valid=%0b fail=%0b idx=%0d occ=%h, expected valid=%0b fail=%0b idx=%0d occ=%h",
                     rq, gnt_valid, gnt_fail, gnt_idx, occupancy, ev, ef, ei, eo);
        end
    endtask

    task automatic idle_inputs();
        req_valid     = 1'b0;
        req_cmd       = 8'h00;
        pair_top_down = 1'b0;
        rel_valid     = 1'b0;
        rel_pair      = 1'b0;
        rel_idx       = 4'd0;
    endtask

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 in reset", 1'b0, 1'b0, 4'd0, 16'h0000);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", 1'b0, 1'b0, 4'd0, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            req_valid     = VT[i].rq;
            req_cmd       = VT[i].cmd;
            pair_top_down = VT[i].td;
            rel_valid     = VT[i].rv;
            rel_pair      = VT[i].rp;
            rel_idx       = VT[i].ri;
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VT[i].tag, i),
                  VT[i].ev, VT[i].ef, VT[i].ei, VT[i].eo);
        end

        // R9: grant pulse drops on the following idle cycle
        idle_inputs();
        @(negedge clk);
        check("R9 pulse ends", 1'b0, 1'b0, 4'd0, 16'hFFFF);

        // R1: reset from a full pool
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", 1'b0, 1'b0, 4'd0, 16'h0000);
        rst = 1'b0;

        // R4 / R5: pair on empty pool, top-down picks 14
        req_valid = 1'b1; req_cmd = 8'h40; pair_top_down = 1'b1;
        @(negedge clk);
        check("R5 top pair after reset", 1'b1, 1'b0, 4'd14, 16'hC000);
        // R3: single still starts at core 0
        req_cmd = 8'h00; pair_top_down = 1'b0;
        @(negedge clk);
        check("R3 single after reset", 1'b1, 1'b0, 4'd0, 16'hC001);
        idle_inputs();
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got no completion, expected end of run");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule